// File: doc/BRIEF.md
# Interleaved Multithread Multiply-Accumulate Element

This block is one processing element of a systolic datapath. It runs several independent copies of the same recurrence over one shared multiplier and adder. Each copy, called a thread, keeps its own accumulator. The thread's next value is its previous value plus the signed product of the two operands that arrive with its sample. Samples from the threads are interleaved one per clock in a fixed rotating order. Each result leaves the element tagged with its thread number, one per clock, in the same order.

The pipeline is as deep as there are threads. A thread's accumulator update is therefore finished long before that thread's next sample is read. The element needs no hazard detection, no forwarding and no stall.

An input whose thread number breaks the rotation is dropped and flagged. Each thread can also be told to restart its accumulation from zero at its next accepted sample. The clear is requested on a per-thread input and held until that slot arrives.

Top module: `mt_sys_pe`

## Requirements
- R1: While `in_vld` is high and `in_tid` equals the expected thread, the sample is accepted in that cycle; one sample per clock is sustained with no bubbles.
- R2: The expected thread starts at 0, steps by one per accepted sample and wraps from NTHR-1 to 0; cycles with `in_vld` low leave it unchanged.
- R3: A valid sample whose `in_tid` differs from the expected thread is dropped. It produces no output, does not advance the expected thread and drives `seq_err` high in the next cycle only.
- R4: An accepted sample presented in cycle c yields exactly one output in cycle c+NTHR, with `out_vld` high and `out_tid` equal to its thread number. `out_vld` is low in every other cycle.
- R5: `out_acc` is the thread's previous accumulator plus the sign-extended product of the signed `in_x` and `in_k`, taken modulo 2^AW. The new value becomes that thread's accumulator.
- R6: A pulse on bit t of `clr_i` makes thread t's next accepted sample start from zero, so `out_acc` equals the product alone. Other threads' accumulators are unaffected.
- R7: A clear bit raised in the same cycle as an accepted sample for that thread applies to that sample.
- R8: After reset, every accumulator is zero, the expected thread is 0, and `out_vld` and `seq_err` are low.
- R9: A clear request stays pending through idle cycles and other threads' samples until the thread's next accepted sample. Repeated requests before that slot act as a single clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input sample valid |
| in_tid | input | TW | Thread number of the input sample |
| in_x | input | DW | Signed first operand |
| in_k | input | DW | Signed second operand |
| clr_i | input | NTHR | Per-thread clear request, one bit per thread |
| out_vld | output | 1 | Result valid |
| out_tid | output | TW | Thread number of the result |
| out_acc | output | AW | Updated accumulator of that thread |
| seq_err | output | 1 | Out-of-order input was dropped in the previous cycle |

## Verification
Two events can meet in one cycle: a clear request for a thread and the accepted sample of that same thread. A second case is a clear raised while that thread's slot is still several samples away. The bench drives a clear on exactly the cycle of a thread's sample, and it also holds and repeats clears across idle cycles and other threads' samples. Each result is judged against a reference model that applies a clear before folding in the sample. The same model also runs against random interleavings of gaps, wrong thread numbers and clear bits.

// File: rtl/mtpe_pkg.sv
package mtpe_pkg;

  // Rotating slot successor used by the order tracker.
  function automatic int unsigned slot_after(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/mtpe_seq.sv
module mtpe_seq #(
  parameter int unsigned NTHR = 4,
  parameter int unsigned TW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [TW-1:0] in_tid,
  output logic          take,
  output logic          seq_err
);
  import mtpe_pkg::*;

  logic [TW-1:0] ptr_q, ptr_d;
  logic          err_q, err_d;
  logic          match;

  assign match = (in_tid == ptr_q);
  assign take  = in_vld & match;

  always_comb begin
    ptr_d = ptr_q;
    if (take) ptr_d = TW'(slot_after(int'(ptr_q), NTHR));
    err_d = in_vld & ~match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      err_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      err_q <= err_d;
    end
  end

  assign seq_err = err_q;

  // R3: an out-of-order sample is flagged and does not move the rotation
  a_r3_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_tid != ptr_q) |=> (seq_err && $stable(ptr_q)));

  // R2: an accepted sample moves the rotation and leaves no flag
  a_r2_step_clean: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!seq_err && ptr_q != $past(ptr_q)));

endmodule

// File: rtl/mtpe_clrq.sv
module mtpe_clrq #(
  parameter int unsigned NTHR = 4,
  parameter int unsigned TW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] clr_i,
  input  logic            take,
  input  logic [TW-1:0]   tid,
  output logic            clr_now
);

  logic [NTHR-1:0] pend_q, pend_d, hit;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign hit[t] = take && (tid == TW'(t));

    always_comb pend_d[t] = (pend_q[t] | clr_i[t]) & ~hit[t];

    // R9: a pending clear survives until its own slot is taken
    a_r9_pend_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[t] && !hit[t]) |=> pend_q[t]);

    // R6: taking the slot consumes the request
    a_r6_pend_used: assert property (@(posedge clk) disable iff (!rst_n)
      hit[t] |=> !pend_q[t]);
  end

  always_comb begin
    clr_now = 1'b0;
    for (int t = 0; t < NTHR; t++)
      if (tid == TW'(t)) clr_now = pend_q[t] | clr_i[t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/mtpe_mac.sv
module mtpe_mac #(
  parameter int unsigned NTHR = 4,
  parameter int unsigned TW   = 2,
  parameter int unsigned DW   = 16,
  parameter int unsigned AW   = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_take,
  input  logic [TW-1:0]        in_tid,
  input  logic signed [DW-1:0] in_x,
  input  logic signed [DW-1:0] in_k,
  input  logic                 in_clr,
  output logic                 res_vld,
  output logic [TW-1:0]        res_tid,
  output logic [AW-1:0]        res_acc
);
  localparam int unsigned PW = 2 * DW;

  // stage 1: operand capture
  logic                 s1_vld;
  logic [TW-1:0]        s1_tid;
  logic signed [DW-1:0] s1_x, s1_k;
  logic                 s1_clr;
  // stage 2: product
  logic                 s2_vld;
  logic [TW-1:0]        s2_tid;
  logic                 s2_clr;
  logic signed [PW-1:0] s2_prod, prod_d;
  // stage 3: accumulate
  logic                 s3_vld;
  logic [TW-1:0]        s3_tid;
  logic [AW-1:0]        s3_acc;

  logic [AW-1:0] bank_q [NTHR];
  logic [AW-1:0] old_acc, sum_d, prod_ext;
  logic [NTHR-1:0] wr_en;

  always_comb begin
    prod_d   = s1_x * s1_k;
    prod_ext = {{(AW-PW){s2_prod[PW-1]}}, s2_prod};
    old_acc  = '0;
    for (int t = 0; t < NTHR; t++)
      if (s2_tid == TW'(t)) old_acc = bank_q[t];
    sum_d = (s2_clr ? '0 : old_acc) + prod_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_tid <= '0; s1_x <= '0; s1_k <= '0; s1_clr <= 1'b0;
      s2_vld <= 1'b0; s2_tid <= '0; s2_clr <= 1'b0; s2_prod <= '0;
      s3_vld <= 1'b0; s3_tid <= '0; s3_acc <= '0;
    end else begin
      s1_vld <= in_take;
      if (in_take) begin
        s1_tid <= in_tid; s1_x <= in_x; s1_k <= in_k; s1_clr <= in_clr;
      end
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_tid <= s1_tid; s2_clr <= s1_clr; s2_prod <= prod_d;
      end
      s3_vld <= s2_vld;
      if (s2_vld) begin
        s3_tid <= s2_tid; s3_acc <= sum_d;
      end
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_bank
    assign wr_en[t] = s2_vld && (s2_tid == TW'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank_q[t] <= '0;
      else if (wr_en[t]) bank_q[t] <= sum_d;
    end
  end

  // R5: a single bank entry is written per accepted sample
  a_r5_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  assign res_vld = s3_vld;
  assign res_tid = s3_tid;
  assign res_acc = s3_acc;

endmodule

// File: rtl/mtpe_dly.sv
module mtpe_dly #(
  parameter int unsigned STG = 1,
  parameter int unsigned W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_vld,
  input  logic [W-1:0] d_dat,
  output logic         q_vld,
  output logic [W-1:0] q_dat
);

  if (STG == 0) begin : g_wire
    logic unused_ck;
    assign unused_ck = clk ^ rst_n;
    assign q_vld = d_vld;
    assign q_dat = d_dat;
  end else begin : g_chain
    logic         v_q [STG];
    logic [W-1:0] p_q [STG];
    for (genvar i = 0; i < STG; i++) begin : g_stg
      logic         v_in;
      logic [W-1:0] p_in;
      if (i == 0) begin : g_head
        assign v_in = d_vld;
        assign p_in = d_dat;
      end else begin : g_body
        assign v_in = v_q[i-1];
        assign p_in = p_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[i] <= 1'b0;
          p_q[i] <= '0;
        end else begin
          v_q[i] <= v_in;
          if (v_in) p_q[i] <= p_in;
        end
      end
    end
    assign q_vld = v_q[STG-1];
    assign q_dat = p_q[STG-1];
  end

endmodule

// File: rtl/mt_sys_pe.sv
module mt_sys_pe #(
  parameter int unsigned NTHR = 4,
  parameter int unsigned DW   = 16,
  parameter int unsigned AW   = 40,
  parameter int unsigned TW   = $clog2(NTHR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [TW-1:0]   in_tid,
  input  logic [DW-1:0]   in_x,
  input  logic [DW-1:0]   in_k,
  input  logic [NTHR-1:0] clr_i,
  output logic            out_vld,
  output logic [TW-1:0]   out_tid,
  output logic [AW-1:0]   out_acc,
  output logic            seq_err
);
  // The datapath holds three stages; NTHR must be at least 3 and AW >= 2*DW.
  localparam int unsigned STG = NTHR - 3;
  localparam int unsigned BW  = TW + AW;

  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic          take, clr_now;
  logic          res_vld;
  logic [TW-1:0] res_tid;
  logic [AW-1:0] res_acc;
  logic [BW-1:0] q_dat;

  mtpe_seq #(.NTHR(NTHR), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .in_vld(in_vld), .in_tid(in_tid),
    .take(take), .seq_err(seq_err)
  );

  mtpe_clrq #(.NTHR(NTHR), .TW(TW)) u_clrq (
    .clk(clk), .rst_n(rst_int_n), .clr_i(clr_i), .take(take),
    .tid(in_tid), .clr_now(clr_now)
  );

  mtpe_mac #(.NTHR(NTHR), .TW(TW), .DW(DW), .AW(AW)) u_mac (
    .clk(clk), .rst_n(rst_int_n), .in_take(take), .in_tid(in_tid),
    .in_x(in_x), .in_k(in_k), .in_clr(clr_now),
    .res_vld(res_vld), .res_tid(res_tid), .res_acc(res_acc)
  );

  mtpe_dly #(.STG(STG), .W(BW)) u_dly (
    .clk(clk), .rst_n(rst_int_n), .d_vld(res_vld), .d_dat({res_tid, res_acc}),
    .q_vld(out_vld), .q_dat(q_dat)
  );

  assign out_tid = q_dat[BW-1:AW];
  assign out_acc = q_dat[AW-1:0];

  // R4: results leave in strict rotating thread order
  logic [TW-1:0] chk_nxt;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   chk_nxt <= '0;
    else if (out_vld) chk_nxt <= (out_tid == TW'(NTHR-1)) ? '0 : out_tid + 1'b1;
  end

  a_r4_out_order: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_vld |-> (out_tid == chk_nxt));

  // R8: reset leaves the outputs quiet
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!out_vld && !seq_err));

endmodule

// File: tb/mt_sys_pe_tb.sv
module mt_sys_pe_tb;
  localparam int NT = 4;
  localparam int DW = 16;
  localparam int AW = 40;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [TW-1:0] in_tid = '0;
  logic [DW-1:0] in_x = '0, in_k = '0;
  logic [NT-1:0] clr_i = '0;
  logic out_vld, seq_err;
  logic [TW-1:0] out_tid;
  logic [AW-1:0] out_acc;

  always #4 clk = ~clk;

  mt_sys_pe #(.NTHR(NT), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_tid(in_tid),
    .in_x(in_x), .in_k(in_k), .clr_i(clr_i),
    .out_vld(out_vld), .out_tid(out_tid), .out_acc(out_acc), .seq_err(seq_err)
  );

  int checks = 0, errors = 0, wd = 0;
  bit done = 0;

  // reference model
  longint acc_m [NT];
  bit     pend_m [NT];
  int     ptr_m = 0;
  bit     err_exp = 0;
  bit          ev [8];
  int          et [8];
  logic [AW-1:0] ea [8];
  string       eg [8];
  int     cyc = 0;
  string  cur_tag = "R8";

  function automatic logic [AW-1:0] mac_ref(input longint base, input int x, input int k);
    longint s;
    s = base + longint'(x) * longint'(k);
    return s[AW-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_out();
    int s = cyc % 8;
    chk(out_vld == ev[s], "R4", "out_vld", longint'(out_vld), longint'(ev[s]));
    if (ev[s] && out_vld) begin
      chk(int'(out_tid) == et[s], "R4", "out_tid", longint'(out_tid), longint'(et[s]));
      chk(out_acc == ea[s], eg[s], "out_acc", longint'(out_acc), longint'(ea[s]));
    end
    chk(seq_err == err_exp, "R3", "seq_err", longint'(seq_err), longint'(err_exp));
    ev[s] = 0;
  endtask

  task automatic step(input bit v, input int tid, input int x, input int k, input logic [NT-1:0] clr);
    int s;
    string tg;
    @(negedge clk);
    check_out();
    in_vld = v; in_tid = tid[TW-1:0]; in_x = x[DW-1:0]; in_k = k[DW-1:0]; clr_i = clr;
    err_exp = 0;
    tg = cur_tag;
    if (v && tid == ptr_m && clr[tid]) tg = "R7";
    for (int t = 0; t < NT; t++) if (clr[t]) pend_m[t] = 1;
    if (v) begin
      if (tid == ptr_m) begin
        s = (cyc + NT) % 8;
        acc_m[tid] = pend_m[tid] ? 0 : acc_m[tid];
        ea[s] = mac_ref(acc_m[tid], x, k);
        acc_m[tid] = longint'(ea[s]);
        pend_m[tid] = 0;
        ev[s] = 1; et[s] = tid; eg[s] = tg;
        ptr_m = (ptr_m + 1) % NT;
      end else err_exp = 1;
    end
    @(posedge clk);
    cyc++;
  endtask

  task automatic round(input bit gaps);
    for (int t = 0; t < NT; t++) begin
      if (gaps && ($urandom % 2 == 0)) step(0, 0, 0, 0, '0);
      step(1, t, int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768, '0);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int t = 0; t < NT; t++) begin acc_m[t] = 0; pend_m[t] = 0; end
    for (int i = 0; i < 8; i++) begin ev[i] = 0; et[i] = 0; ea[i] = '0; eg[i] = "R5"; end
    // R8: outputs quiet during and right after reset
    repeat (3) begin
      @(negedge clk);
      chk(out_vld == 0, "R8", "out_vld in reset", longint'(out_vld), 0);
      chk(seq_err == 0, "R8", "seq_err in reset", longint'(seq_err), 0);
    end
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R8: first round starts from zero accumulators at thread 0
    cur_tag = "R8";
    step(1, 0, 3, 5, '0); step(1, 1, -7, 9, '0); step(1, 2, 100, -100, '0); step(1, 3, -32768, -32768, '0);
    // R1: back-to-back rounds
    cur_tag = "R1";
    repeat (4) round(0);
    // R2: gaps do not move the rotation
    cur_tag = "R2";
    repeat (3) round(1);
    // R3: out-of-order samples dropped
    cur_tag = "R3";
    step(1, 2, 11, 11, '0); step(1, 0, 1, 2, '0); step(1, 3, 5, 5, '0); step(1, 1, 3, 3, '0);
    step(1, 1, 9, 9, '0); step(1, 2, 4, 4, '0); step(1, 3, 2, 2, '0);
    // R6: clear for thread 2 raised during thread 0 slot
    cur_tag = "R6";
    step(1, 0, 6, 6, 4'b0100); step(1, 1, 7, 7, '0); step(1, 2, 8, 8, '0); step(1, 3, 9, 9, '0);
    round(0);
    // R7: clear in the same cycle as the thread's sample
    cur_tag = "R7";
    step(1, 0, 2, 2, '0); step(1, 1, 123, -4, 4'b0010); step(1, 2, 5, 5, '0); step(1, 3, 1, 1, '0);
    round(0);
    // R9: clear for thread 3 held and repeated across gaps and other threads
    cur_tag = "R9";
    step(0, 0, 0, 0, 4'b1000); step(0, 0, 0, 0, 4'b1000); step(1, 0, 1, 1, 4'b1000);
    step(0, 0, 0, 0, '0); step(1, 1, 1, 1, 4'b1000); step(1, 2, 1, 1, '0); step(1, 3, 50, 2, '0);
    round(0);
    // R5: wraparound modulo 2^AW with extreme operands
    cur_tag = "R5";
    repeat (1100)
      for (int t = 0; t < NT; t++) step(1, t, -32768, -32768, '0);
    // R5: random mix of gaps, wrong threads and clears
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 100);
      int tid = ptr_m;
      logic [NT-1:0] c = '0;
      if (r < 10) tid = (ptr_m + 1 + int'($urandom % (NT - 1))) % NT;
      if ($urandom % 20 == 0) c[$urandom % NT] = 1'b1;
      step(r < 85, tid, int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768, c);
    end
    repeat (NT + 2) step(0, 0, 0, 0, '0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule